// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is the control logic of a NOR flash device with a protected boot block. Each strobed bus write is decoded as a command. Two-write sequences start an automated word program or a block erase, and the result is reported through an 8-bit status byte. A behavioural array with fixed program and erase delays stands in for the storage cells. The array is scaled down, but it keeps the block arrangement of the device. The address space holds 128 units of `UNIT_WORDS` words. The boot block spans 2 units, each of the two parameter blocks spans 1 unit, a mid-size main block spans 12 units, and seven large main blocks span 16 units each. `TOP_BOOT` mirrors this arrangement so that the boot block sits at the highest addresses instead of the lowest.

The same address bus serves reads and writes. The read port returns either an array word or the status byte, depending on the current read mode. While an operation runs, the read port always returns the status byte. Lock decisions are taken when the second write of a sequence arrives. They combine the write-protect pin, a high-voltage flag on the reset pin and a supply-lockout flag. A refused program or erase sets a failure bit and leaves the array unchanged. An erase can be suspended so that the array can be read, and then resumed. A power-up reset or the reset pin returns the block to array reads and aborts any operation in progress.

Top module: `bbf_flash_ctrl`

## Requirements
- R1: After power-up reset (`rst`), every array word reads 0xFF, `ready` is 1 and reads return array data. Asserting `rp_low` for one cycle aborts any running operation, returns to array reads and clears the status flags. The contents of an aborted erase block remain unchanged.
- R2: A write of 0x40 followed by a data write programs the word at the data address with the AND of its old value and the data. The block is busy for `PROG_CYC` cycles after the data write.
- R3: A write of 0x20 followed by a write of 0xD0 sets every word of the block that holds the confirm address to 0xFF. The block is busy for `ERASE_CYC` cycles after the confirm write.
- R4: Block decoding follows the scaled arrangement. With boot at the bottom, the block ranges in words are [0,2U), [2U,3U), [3U,4U), [4U,16U) and then 16U-word blocks, where U = `UNIT_WORDS`. An erase leaves every word outside the target block unchanged. With `TOP_BOOT`=1, the arrangement is mirrored, so the boot block holds the two highest units.
- R5: While `wp_n`=0 and `rp_hv`=0, a program aimed at the boot block sets status bit 4 and an erase aimed at it sets status bit 5. In both cases the array is left unchanged.
- R6: With `wp_n`=1, or with `rp_hv`=1 whatever `wp_n` is, the boot block programs normally.
- R7: While `vpp_lo`=1, a program to any block sets bit 4 and an erase to any block sets bit 5. Nothing in the array changes.
- R8: An erase setup followed by any value other than 0xD0 sets both bit 4 and bit 5.
- R9: The status byte has bit 7 = ready, bit 6 = erase suspended, bit 5 = erase failure and bit 4 = program failure, with bits 3..0 at 0. The failure bits stay set until a 0x50 write.
- R10: While busy, reads return the status byte, and every write other than 0xB0 during an erase is ignored.
- R11: A write of 0xB0 during an erase suspends it. The status then reads 0xC0, 0xFF shows the not-yet-erased array, and 0xD0 resumes the erase with its remaining cycle count.
- R12: A 0xB0 write sampled in the final cycle of an erase is dropped. The erase completes and bit 6 stays 0.
- R13: A write of 0x70 selects status reads and a write of 0xFF selects array reads. Both program setup and erase setup also select status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset; also erases the model array |
| rp_low | input | 1 | Reset pin asserted: abort and return to array reads |
| rp_hv | input | 1 | Reset pin at high voltage: boot block unlocked |
| wp_n | input | 1 | Write protect, low locks the boot block |
| vpp_lo | input | 1 | Program supply below lockout: all blocks locked |
| we | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data or command code (low 8 bits) |
| rdata | output | DATA_W | Array word or status byte |
| ready | output | 1 | State machine idle (status bit 7) |

## Verification
The case that needs care is an erase suspend that arrives on the same edge at which the erase counter expires. The bench counts cycles from the confirm write and places 0xB0 exactly on the completion edge. It then expects status 0x80 and an erased block. It repeats the case one cycle earlier and expects status 0xC0 there. After a resume in that second case, it expects the erase to finish after the single remaining cycle. The same cycle accounting shows that a read-array command sent right after a confirm write is ignored.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

    localparam int UNITS   = 128;
    localparam int UNIT_AW = 7;
    localparam int BLK_W   = 4;

    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_PROG     = 8'h40;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PSETUP,
        ST_ESETUP,
        ST_PBUSY,
        ST_EBUSY,
        ST_ESUSP
    } ctl_st_e;

    typedef struct packed {
        logic       ready;
        logic       susp;
        logic       efail;
        logic       pfail;
        logic [3:0] zero;
    } status_t;

    // Block id 0 is always the boot block; ids count away from it.
    function automatic logic [BLK_W-1:0] blk_of(input logic [UNIT_AW-1:0] unit,
                                                 input bit top);
        logic [UNIT_AW-1:0] u;
        u = top ? (UNIT_AW'(UNITS - 1) - unit) : unit;
        if (u < 7'd2)       return 4'd0;
        else if (u == 7'd2) return 4'd1;
        else if (u == 7'd3) return 4'd2;
        else if (u < 7'd16) return 4'd3;
        else                return 4'd4 + 4'((u - 7'd16) >> 4);
    endfunction

endpackage

// File: rtl/bbf_block_map.sv
module bbf_block_map
    import bbf_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BLK_W-1:0]  blk,
    output logic              boot
);
    logic [UNIT_AW-1:0] unit;

    assign unit = addr[ADDR_W-1 -: UNIT_AW];
    assign blk  = blk_of(unit, TOP_BOOT);
    assign boot = (blk == '0);
endmodule

// File: rtl/bbf_array.sv
module bbf_array
    import bbf_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 8,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int UNIT_LG = ADDR_W - UNIT_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (blk_of(UNIT_AW'(i >> UNIT_LG), TOP_BOOT) == erase_blk)
                    mem[i] <= '1;
        end else if (prog_en) begin
            mem[prog_addr] <= mem[prog_addr] & prog_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R4: the two array actions never coincide
    erase_prog_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(erase_en && prog_en));
endmodule

// File: rtl/bbf_cmd_ctrl.sv
module bbf_cmd_ctrl
    import bbf_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 8,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rp_low,
    input  logic              rp_hv,
    input  logic              wp_n,
    input  logic              vpp_lo,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BLK_W-1:0]  addr_blk,
    input  logic              addr_boot,
    output logic              prog_en,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_en,
    output logic [BLK_W-1:0]  erase_blk,
    output status_t           status,
    output logic              show_status
);
    localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    ctl_st_e          st;
    logic [CNT_W-1:0] cnt;
    logic             rd_stat, pfail, efail;
    logic [7:0]       cmd;
    logic             locked, busy;

    assign cmd    = wdata[7:0];
    assign locked = vpp_lo || (addr_boot && !wp_n && !rp_hv);
    assign busy   = (st == ST_PBUSY) || (st == ST_EBUSY);

    always_ff @(posedge clk) begin
        if (rst || rp_low) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            rd_stat   <= 1'b0;
            pfail     <= 1'b0;
            efail     <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
            erase_blk <= '0;
        end else begin
            case (st)
                ST_IDLE: if (we) begin
                    case (cmd)
                        CMD_RD_ARRAY: rd_stat <= 1'b0;
                        CMD_RD_STAT:  rd_stat <= 1'b1;
                        CMD_CLR_STAT: begin pfail <= 1'b0; efail <= 1'b0; end
                        CMD_PROG:     begin st <= ST_PSETUP; rd_stat <= 1'b1; end
                        CMD_ERASE:    begin st <= ST_ESETUP; rd_stat <= 1'b1; end
                        default: ;
                    endcase
                end
                ST_PSETUP: if (we) begin
                    if (locked) begin
                        pfail <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        prog_addr <= addr;
                        prog_data <= wdata;
                        cnt       <= CNT_W'(PROG_CYC - 1);
                        st        <= ST_PBUSY;
                    end
                end
                ST_ESETUP: if (we) begin
                    if (cmd != CMD_CONFIRM) begin
                        pfail <= 1'b1;
                        efail <= 1'b1;
                        st    <= ST_IDLE;
                    end else if (locked) begin
                        efail <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        erase_blk <= addr_blk;
                        cnt       <= CNT_W'(ERASE_CYC - 1);
                        st        <= ST_EBUSY;
                    end
                end
                ST_PBUSY: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                ST_EBUSY: begin
                    if (cnt == '0)                     st <= ST_IDLE;
                    else if (we && cmd == CMD_SUSPEND) st <= ST_ESUSP;
                    else                               cnt <= cnt - 1'b1;
                end
                ST_ESUSP: if (we) begin
                    case (cmd)
                        CMD_RD_ARRAY: rd_stat <= 1'b0;
                        CMD_RD_STAT:  rd_stat <= 1'b1;
                        CMD_CONFIRM:  begin st <= ST_EBUSY; rd_stat <= 1'b1; end
                        default: ;
                    endcase
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign prog_en     = (st == ST_PBUSY) && (cnt == '0);
    assign erase_en    = (st == ST_EBUSY) && (cnt == '0);
    assign status      = '{ready: !busy, susp: (st == ST_ESUSP),
                           efail: efail, pfail: pfail, zero: 4'h0};
    assign show_status = rd_stat || busy;

    // R1
    rp_abort_chk: assert property (@(posedge clk) disable iff (rst)
        rp_low |=> (st == ST_IDLE) && !rd_stat && !pfail && !efail);
    // R5
    lock_prog_chk: assert property (@(posedge clk) disable iff (rst || rp_low)
        (st == ST_PSETUP && we && locked) |=> (st == ST_IDLE) && pfail);
    // R8
    seq_err_chk: assert property (@(posedge clk) disable iff (rst || rp_low)
        (st == ST_ESETUP && we && cmd != CMD_CONFIRM) |=> pfail && efail);
    // R9
    sticky_fail_chk: assert property (@(posedge clk) disable iff (rst || rp_low)
        (pfail && !(st == ST_IDLE && we && cmd == CMD_CLR_STAT)) |=> pfail);
    // R11
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst || rp_low)
        (st == ST_EBUSY && cnt != '0 && we && cmd == CMD_SUSPEND)
            |=> (st == ST_ESUSP) && $stable(cnt));
    // R12
    finish_wins_chk: assert property (@(posedge clk) disable iff (rst || rp_low)
        (st == ST_EBUSY && cnt == '0) |=> (st == ST_IDLE));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst || rp_low)
        (st == ST_PBUSY && we) |=> $stable(rd_stat) && $stable(prog_data));
endmodule

// File: rtl/bbf_flash_ctrl.sv
module bbf_flash_ctrl
    import bbf_pkg::*;
#(
    parameter int UNIT_WORDS = 4,
    parameter int DATA_W     = 8,
    parameter bit TOP_BOOT   = 1'b0,
    parameter int PROG_CYC   = 4,
    parameter int ERASE_CYC  = 16,
    localparam int ADDR_W    = UNIT_AW + $clog2(UNIT_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rp_low,
    input  logic              rp_hv,
    input  logic              wp_n,
    input  logic              vpp_lo,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    logic [BLK_W-1:0]  addr_blk, erase_blk;
    logic              addr_boot, prog_en, erase_en, show_status;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data, arr_rd;
    status_t           status;

    bbf_block_map #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) map_i (
        .addr(addr), .blk(addr_blk), .boot(addr_boot));

    bbf_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) ctrl_i (
        .clk(clk), .rst(rst), .rp_low(rp_low), .rp_hv(rp_hv), .wp_n(wp_n),
        .vpp_lo(vpp_lo), .we(we), .addr(addr), .wdata(wdata),
        .addr_blk(addr_blk), .addr_boot(addr_boot),
        .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_en(erase_en), .erase_blk(erase_blk),
        .status(status), .show_status(show_status));

    bbf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_BOOT(TOP_BOOT)) arr_i (
        .clk(clk), .rst(rst), .prog_en(prog_en), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_en(erase_en), .erase_blk(erase_blk),
        .rd_addr(addr), .rd_data(arr_rd));

    assign rdata = show_status ? DATA_W'(status) : arr_rd;
    assign ready = status.ready;

    // R10
    busy_reads_status_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rdata == DATA_W'(status)));
endmodule

// File: tb/bbf_flash_ctrl_tb_top.sv
module bbf_flash_ctrl_tb_top;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [8:0] a;
        logic [7:0] d;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 54;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 9'd5,  8'hFF, 4'd1},   // R1 erased after power-up
        '{OP_WR, 9'd0,  8'h70, 4'd13},  // R13
        '{OP_RD, 9'd0,  8'h80, 4'd13},
        '{OP_WR, 9'd20, 8'h40, 4'd2},   // R2
        '{OP_WR, 9'd20, 8'hA5, 4'd2},
        '{OP_RD, 9'd20, 8'h00, 4'd10},  // R10 busy shows status
        '{OP_WT, 9'd0,  8'd4,  4'd2},
        '{OP_RD, 9'd20, 8'h80, 4'd9},   // R9
        '{OP_WR, 9'd0,  8'hFF, 4'd13},
        '{OP_RD, 9'd20, 8'hA5, 4'd2},
        '{OP_WR, 9'd20, 8'h40, 4'd2},
        '{OP_WR, 9'd20, 8'h0F, 4'd2},
        '{OP_WT, 9'd0,  8'd4,  4'd2},
        '{OP_WR, 9'd0,  8'hFF, 4'd13},
        '{OP_RD, 9'd20, 8'h05, 4'd2},   // R2 AND with old value
        '{OP_WR, 9'd21, 8'h40, 4'd2},
        '{OP_WR, 9'd21, 8'h3C, 4'd2},
        '{OP_WT, 9'd0,  8'd4,  4'd2},
        '{OP_WR, 9'd63, 8'h40, 4'd2},
        '{OP_WR, 9'd63, 8'h22, 4'd2},
        '{OP_WT, 9'd0,  8'd4,  4'd2},
        '{OP_WR, 9'd70, 8'h40, 4'd2},
        '{OP_WR, 9'd70, 8'h11, 4'd2},
        '{OP_WT, 9'd0,  8'd4,  4'd2},
        '{OP_WR, 9'd15, 8'h40, 4'd2},
        '{OP_WR, 9'd15, 8'h33, 4'd2},
        '{OP_WT, 9'd0,  8'd4,  4'd2},
        '{OP_WR, 9'd30, 8'h20, 4'd3},   // R3 erase block 16..63
        '{OP_WR, 9'd30, 8'hD0, 4'd3},
        '{OP_WT, 9'd0,  8'd16, 4'd3},
        '{OP_WR, 9'd0,  8'hFF, 4'd13},
        '{OP_RD, 9'd20, 8'hFF, 4'd3},
        '{OP_RD, 9'd63, 8'hFF, 4'd3},
        '{OP_RD, 9'd70, 8'h11, 4'd4},   // R4 neighbour above untouched
        '{OP_RD, 9'd15, 8'h33, 4'd4},   // R4 neighbour below untouched
        '{OP_RD, 9'd21, 8'hFF, 4'd3},
        '{OP_WR, 9'd0,  8'h20, 4'd8},   // R8
        '{OP_WR, 9'd0,  8'hFF, 4'd8},
        '{OP_RD, 9'd0,  8'hB0, 4'd8},
        '{OP_WR, 9'd0,  8'h50, 4'd9},
        '{OP_RD, 9'd0,  8'h80, 4'd9},
        '{OP_WR, 9'd3,  8'h40, 4'd6},   // R6 boot with wp_n high
        '{OP_WR, 9'd3,  8'h12, 4'd6},
        '{OP_WT, 9'd0,  8'd4,  4'd6},
        '{OP_WR, 9'd0,  8'hFF, 4'd13},
        '{OP_RD, 9'd3,  8'h12, 4'd6},
        '{OP_WR, 9'd40, 8'h20, 4'd10},
        '{OP_WR, 9'd40, 8'hD0, 4'd10},
        '{OP_WR, 9'd0,  8'hFF, 4'd10},  // R10 ignored while busy
        '{OP_RD, 9'd0,  8'h00, 4'd10},
        '{OP_WT, 9'd0,  8'd15, 4'd10},
        '{OP_RD, 9'd0,  8'h80, 4'd10},
        '{OP_WR, 9'd0,  8'hFF, 4'd13},
        '{OP_RD, 9'd70, 8'h11, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1, rp_low = 1'b0, rp_hv = 1'b0, wp_n = 1'b1, vpp_lo = 1'b0;
    logic       we = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, rdata_t;
    logic       ready, ready_t;
    int         n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    bbf_flash_ctrl dut_i (
        .clk(clk), .rst(rst), .rp_low(rp_low), .rp_hv(rp_hv), .wp_n(wp_n),
        .vpp_lo(vpp_lo), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready));

    bbf_flash_ctrl #(.TOP_BOOT(1'b1)) dut_top_i (
        .clk(clk), .rst(rst), .rp_low(rp_low), .rp_hv(rp_hv), .wp_n(wp_n),
        .vpp_lo(vpp_lo), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata_t), .ready(ready_t));

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write is sampled at the following posedge
    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [7:0] exp, input string tag);
        addr = a; #1;
        check(rdata, exp, tag);
    endtask

    task automatic rdt(input logic [8:0] a, input logic [7:0] exp, input string tag);
        addr = a; #1;
        check(rdata_t, exp, tag);
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check({7'd0, ready}, 8'd1, "R1 ready after power-up");

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR: wr(VEC[i].a, VEC[i].d);
                OP_RD: rd(VEC[i].a, VEC[i].d, $sformatf("R%0d vector %0d", VEC[i].req, i));
                default: wt(int'(VEC[i].d));
            endcase
        end

        // R5: boot locked by wp_n low
        wp_n = 1'b0;
        wr(9'd2, 8'h40); wr(9'd2, 8'h00);
        rd(9'd0, 8'h90, "R5 program refused");
        wr(9'd0, 8'h50);
        wr(9'd3, 8'h20); wr(9'd3, 8'hD0);
        rd(9'd0, 8'hA0, "R5 erase refused");
        wr(9'd0, 8'hFF);
        rd(9'd3, 8'h12, "R5 boot data kept");
        rd(9'd2, 8'hFF, "R5 boot word unprogrammed");
        wr(9'd0, 8'h50);

        // R6: high-voltage override
        rp_hv = 1'b1;
        wr(9'd4, 8'h40); wr(9'd4, 8'h44); wt(4);
        wr(9'd0, 8'hFF);
        rd(9'd4, 8'h44, "R6 override programs boot");
        rp_hv = 1'b0; wp_n = 1'b1;

        // R7: supply lockout
        vpp_lo = 1'b1;
        wr(9'd70, 8'h40); wr(9'd70, 8'h00);
        rd(9'd0, 8'h90, "R7 program refused");
        wr(9'd0, 8'h50);
        wr(9'd70, 8'h20); wr(9'd70, 8'hD0);
        rd(9'd0, 8'hA0, "R7 erase refused");
        wr(9'd0, 8'h50); wr(9'd0, 8'hFF);
        rd(9'd70, 8'h11, "R7 array unchanged");
        vpp_lo = 1'b0;

        // R11: suspend and resume
        wr(9'd70, 8'h20); wr(9'd70, 8'hD0); wt(3);
        wr(9'd0, 8'hB0);
        rd(9'd0, 8'hC0, "R11 suspended status");
        wr(9'd0, 8'hFF);
        rd(9'd70, 8'h11, "R11 array readable while suspended");
        wr(9'd0, 8'hD0);
        rd(9'd0, 8'h00, "R11 resumed busy");
        wt(20);
        rd(9'd0, 8'h80, "R11 erase done");
        wr(9'd0, 8'hFF);
        rd(9'd70, 8'hFF, "R11 block erased");

        // R12: suspend on the completion edge is dropped
        wr(9'd80, 8'h40); wr(9'd80, 8'h55); wt(4);
        wr(9'd80, 8'h20); wr(9'd80, 8'hD0); wt(15);
        wr(9'd0, 8'hB0);
        rd(9'd0, 8'h80, "R12 completion beats suspend");
        wr(9'd0, 8'hFF);
        rd(9'd80, 8'hFF, "R12 erased");

        // R11: suspend one cycle before completion, resume finishes in one cycle
        wr(9'd80, 8'h40); wr(9'd80, 8'h55); wt(4);
        wr(9'd80, 8'h20); wr(9'd80, 8'hD0); wt(14);
        wr(9'd0, 8'hB0);
        rd(9'd0, 8'hC0, "R11 late suspend taken");
        wr(9'd0, 8'hD0); wt(2);
        rd(9'd0, 8'h80, "R11 last cycle after resume");
        wr(9'd0, 8'hFF);
        rd(9'd80, 8'hFF, "R11 erased after resume");

        // R1: reset pin aborts an erase
        wr(9'd90, 8'h40); wr(9'd90, 8'h66); wt(4);
        wr(9'd90, 8'h20); wr(9'd90, 8'hD0); wt(3);
        rp_low = 1'b1; @(negedge clk); rp_low = 1'b0;
        rd(9'd90, 8'h66, "R1 abort keeps contents in array mode");
        check({7'd0, ready}, 8'd1, "R1 ready after abort");
        wr(9'd0, 8'h70);
        rd(9'd0, 8'h80, "R1 status cleared");

        // R4: top-boot variant, fresh power-up for both
        rst = 1'b1; wt(2); rst = 1'b0;
        wp_n = 1'b0;
        wr(9'd511, 8'h40); wr(9'd511, 8'h00); wt(4);
        wr(9'd0, 8'h70);
        rd(9'd0, 8'h80, "R4 bottom-boot: top word is main block");
        rdt(9'd0, 8'h90, "R4 top-boot: top word locked");
        wr(9'd0, 8'h50);
        wr(9'd0, 8'h40); wr(9'd0, 8'h00); wt(4);
        rd(9'd0, 8'h90, "R4 bottom-boot: word 0 locked");
        rdt(9'd0, 8'h80, "R4 top-boot: word 0 is main block");
        wp_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule